// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a watchdog timer that software reaches through a small bank of 32-bit registers. An up-counter advances once per clock while it is enabled. On every clock its value is compared for equality with a programmed match value. A match can trigger any mix of these actions: set an interrupt flag, stop the counter and return it to zero, change an external match pin, or start a reset pulse on an internal reset output, an external reset output, or both. Software can also force either reset output directly. The pulse length comes from a register and lasts that value plus a fixed extension.

Software restarts the watchdog by clearing the counter through the control register and then enabling it again. The counter can be set to freeze while a debug-halt input is high. A reset-cause flag records that the watchdog issued a reset. The ordinary synchronous reset does not clear this flag, so software can read it after the system restarts. Only the power-on reset input clears it.

Top module: `wdt_timer`

## Requirements
- R1: While `rst_n` or `por_n` is low at a clock edge, every register returns to zero and all outputs are low. The reset-cause flag is the one exception and is governed by R10.
- R2: `bus_addr` is the word index into the register bank: 0 interrupt status, 1 control, 2 counter (read-only), 3 match control, 4 match value, 5 external match control, 6 pulse length, 7 reset cause. A write is captured at the next clock edge. `bus_rdata` combinationally returns the selected register. Bit 1 of match control is reserved and reads 0.
- R3: Control bit 0 enables counting, and the counter then adds one per clock. Control bit 1 holds the counter at zero and stops it, so the counter reads zero one clock after the write edge. Writing control with 0 stops the counter without clearing it.
- R4: With control bit 2 set, the counter holds its value while `dbg_halt` is high. With control bit 2 clear, `dbg_halt` has no effect.
- R5: A match occurs in a cycle where the counter is running and equals the match value. If match-control bit 0 is set, a match sets interrupt-status bit 0, which drives `irq`. Writing 1 to that bit clears it. When a set and a clear arrive in the same cycle, the set wins.
- R6: If match-control bit 2 is set, the edge after a match returns the counter to zero and clears control bit 0.
- R7: Match-control bits 3 and 4 make a match start a pulse on `rst_int_o` and `rst_ext_o` respectively. The pulse begins at the edge after the match and lasts pulse length + 6 clocks.
- R8: While match-control bit 5 (internal) or bit 6 (external) is set, the matching reset output is held high from the next edge on. After the bit is cleared, the output stays high for a further pulse length + 6 clocks, counted from the last edge at which the bit was still set.
- R9: External match control bits [5:4] choose the action on a match: 0 keep, 1 drive low, 2 drive high, 3 toggle. Bit 0 holds the current level, which drives `match_out` and can also be written directly.
- R10: The reset-cause flag (register 7, bit 0) is set at the edge where any reset pulse starts. Bus writes do not change it, and it keeps its value through `rst_n`. Only `por_n` low clears it.
- R11: When stop-on-match is not selected, the counter wraps from all ones to zero.
- R12: A pulse length of 0xFFFF gives a reset pulse exactly 65541 clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears reset cause |
| dbg_halt | input | 1 | Debug halt request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Match interrupt flag |
| match_out | output | 1 | External match level |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |

## Verification
The match path is driven in several ways. A match-triggered stop with both reset outputs separates the stop behaviour from the pulse length. A toggle action on a second match shows that the external level depends on its previous state and not only on the selected action. A forced reset held over several cycles shows that the pulse is reloaded on every cycle the force bit is set, not started only once. A long free run with stop disabled exercises the wrap. The maximum pulse length separates the fixed extension of six clocks from an off-by-one.

// File: rtl/wdt_pkg.sv
// Shared types for the watchdog timer.
// Assumes a 32-bit register bus addressed by word index.
package wdt_pkg;

    // Word index of each register; software address maps rely on this order
    typedef enum logic [2:0] {
        IDX_INT   = 3'd0,
        IDX_CTRL  = 3'd1,
        IDX_CNT   = 3'd2,
        IDX_MCTL  = 3'd3,
        IDX_MVAL  = 3'd4,
        IDX_EXT   = 3'd5,
        IDX_PLEN  = 3'd6,
        IDX_CAUSE = 3'd7
    } reg_idx_e;

    // Control register fields, bit 2 down to bit 0
    typedef struct packed {
        logic freeze_en;
        logic clr;
        logic run_en;
    } ctrl_t;

    // Match-control fields, bit 6 down to bit 0
    typedef struct packed {
        logic force_ext;
        logic force_int;
        logic rst_ext;
        logic rst_int;
        logic stop;
        logic rsvd;
        logic irq_en;
    } mctl_t;

    // Action applied to the external match level on a match
    typedef enum logic [1:0] {
        EM_KEEP   = 2'd0,
        EM_LOW    = 2'd1,
        EM_HIGH   = 2'd2,
        EM_TOGGLE = 2'd3
    } em_act_e;

    localparam int NUM_RST = 2;

endpackage

// File: rtl/wdt_counter.sv
// Up-counter for the watchdog timer.
// It clears while clr_i is high, returns to zero on stop_i and otherwise
// increments while enabled and not frozen. Wraps at its width.
// Assumes: stop_i is asserted only in a cycle where run_o is high.
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             freeze_i,
    input  logic             stop_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o
);

    // Counting is allowed only when enabled, not cleared and not frozen
    assign run_o = en_i && !clr_i && !freeze_i;

    // Count value update
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clr_i)  cnt_o <= '0;
        else if (stop_i) cnt_o <= '0;
        else if (run_o)  cnt_o <= cnt_o + 1'b1;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !clr_i) |=> $stable(cnt_o)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !clr_i && !stop_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R11

endmodule

// File: rtl/wdt_pulse.sv
// Reset pulse stretcher.
// A start loads length + EXTRA. The output stays high while the remaining
// count is nonzero. A start while the pulse is running reloads the count.
module wdt_pulse #(
    parameter int LEN_W = 16,
    parameter int EXTRA = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             out_o
);

    localparam int REM_W = LEN_W + 1;

    logic [REM_W-1:0] remain_q;

    // Remaining pulse length: reload on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                remain_q <= '0;
        else if (start_i)          remain_q <= REM_W'(len_i) + REM_W'(EXTRA);
        else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
    end

    assign out_o = (remain_q != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> out_o); // R7

    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !out_o) |=> !out_o); // R8

endmodule

// File: rtl/wdt_extmatch.sv
// External match level register.
// A bus write sets both the action and the level. Otherwise a match applies
// the stored action to the level.
module wdt_extmatch
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [1:0] act_i,
    input  logic       lvl_i,
    input  logic       hit_i,
    output logic [1:0] act_o,
    output logic       level_o
);

    em_act_e act_q;

    // Action and level update; a bus write takes priority over a match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= EM_KEEP;
            level_o <= 1'b0;
        end else if (we_i) begin
            act_q   <= em_act_e'(act_i);
            level_o <= lvl_i;
        end else if (hit_i) begin
            case (act_q)
                EM_LOW:    level_o <= 1'b0;
                EM_HIGH:   level_o <= 1'b1;
                EM_TOGGLE: level_o <= ~level_o;
                default:   level_o <= level_o;
            endcase
        end
    end

    assign act_o = act_q;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !hit_i) |=> $stable(level_o)); // R9

endmodule

// File: rtl/wdt_timer.sv
// Match-compare watchdog timer: register bank, match logic, interrupt flag,
// two reset pulse generators and a sticky reset-cause flag.
// Assumes: single clock domain; rst_n and por_n are synchronous active-low.
// The reset-cause flag is cleared by por_n only.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PLEN_W      = 16,
    parameter int PULSE_EXTRA = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        dbg_halt,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        match_out,
    output logic        rst_int_o,
    output logic        rst_ext_o
);

    localparam logic [6:0] MCTL_MASK = 7'b111_1101;

    logic             rst_all_n;
    reg_idx_e         widx;
    logic             wr_int, wr_ctrl, wr_mctl, wr_mval, wr_ext, wr_plen;
    ctrl_t            ctrl_q;
    mctl_t            mctl_q;
    logic [CNT_W-1:0] mval_q;
    logic [PLEN_W-1:0] plen_q;
    logic             flag_q;
    logic             cause_q;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             stop_hit;
    logic [NUM_RST-1:0] start;
    logic [NUM_RST-1:0] pulse;
    logic [1:0]       ext_act;

    assign rst_all_n = rst_n & por_n;
    assign widx      = reg_idx_e'(bus_addr);
    assign wr_int    = bus_we && (widx == IDX_INT);
    assign wr_ctrl   = bus_we && (widx == IDX_CTRL);
    assign wr_mctl   = bus_we && (widx == IDX_MCTL);
    assign wr_mval   = bus_we && (widx == IDX_MVAL);
    assign wr_ext    = bus_we && (widx == IDX_EXT);
    assign wr_plen   = bus_we && (widx == IDX_PLEN);

    wdt_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .en_i     (ctrl_q.run_en),
        .clr_i    (ctrl_q.clr),
        .freeze_i (ctrl_q.freeze_en && dbg_halt),
        .stop_i   (stop_hit),
        .run_o    (run),
        .cnt_o    (cnt)
    );

    // Equality compare, evaluated every clock while counting
    assign hit      = run && (cnt == mval_q);
    assign stop_hit = hit && mctl_q.stop;

    // Control register; a stop on match drops the enable unless software writes
    always_ff @(posedge clk) begin
        if (!rst_all_n)    ctrl_q        <= '0;
        else if (wr_ctrl)  ctrl_q        <= ctrl_t'(bus_wdata[2:0]);
        else if (stop_hit) ctrl_q.run_en <= 1'b0;
    end

    // Match control, match value and pulse length registers
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            mctl_q <= '0;
            mval_q <= '0;
            plen_q <= '0;
        end else begin
            if (wr_mctl) mctl_q <= mctl_t'(bus_wdata[6:0] & MCTL_MASK);
            if (wr_mval) mval_q <= bus_wdata[CNT_W-1:0];
            if (wr_plen) plen_q <= bus_wdata[PLEN_W-1:0];
        end
    end

    // Interrupt flag: set on an enabled match, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_all_n)                    flag_q <= 1'b0;
        else if (hit && mctl_q.irq_en)     flag_q <= 1'b1;
        else if (wr_int && bus_wdata[0])   flag_q <= 1'b0;
    end

    assign irq = flag_q;

    // Pulse triggers: a match with the reset enable set, or a force bit
    assign start[0] = (hit && mctl_q.rst_int) || mctl_q.force_int;
    assign start[1] = (hit && mctl_q.rst_ext) || mctl_q.force_ext;

    for (genvar g = 0; g < NUM_RST; g++) begin : g_pulse
        wdt_pulse #(.LEN_W(PLEN_W), .EXTRA(PULSE_EXTRA)) u_pulse (
            .clk     (clk),
            .rst_n   (rst_all_n),
            .start_i (start[g]),
            .len_i   (plen_q),
            .out_o   (pulse[g])
        );
    end

    assign rst_int_o = pulse[0];
    assign rst_ext_o = pulse[1];

    // Reset-cause flag: kept through rst_n, cleared only by power-on reset
    always_ff @(posedge clk) begin
        if (!por_n)                  cause_q <= 1'b0;
        else if (rst_n && |start)    cause_q <= 1'b1;
    end

    wdt_extmatch u_ext (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .we_i    (wr_ext),
        .act_i   (bus_wdata[5:4]),
        .lvl_i   (bus_wdata[0]),
        .hit_i   (hit),
        .act_o   (ext_act),
        .level_o (match_out)
    );

    // Read data multiplexer
    always_comb begin
        case (widx)
            IDX_INT:   bus_rdata = 32'(flag_q);
            IDX_CTRL:  bus_rdata = 32'(ctrl_q);
            IDX_CNT:   bus_rdata = 32'(cnt);
            IDX_MCTL:  bus_rdata = 32'(mctl_q);
            IDX_MVAL:  bus_rdata = 32'(mval_q);
            IDX_EXT:   bus_rdata = 32'({ext_act, 3'b000, match_out});
            IDX_PLEN:  bus_rdata = 32'(plen_q);
            default:   bus_rdata = 32'(cause_q);
        endcase
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_ctrl && bus_wdata[1]) |=> ##1 (cnt == '0)); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(flag_q) |-> $past(hit && mctl_q.irq_en)); // R5

    AST_STOP_MATCH: assert property (@(posedge clk) disable iff (!rst_all_n)
        (stop_hit && !wr_ctrl) |=> (!ctrl_q.run_en && cnt == '0)); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q); // R10

endmodule

// File: tb/wdt_timer_test.sv
// Bench for wdt_timer: behavioural reference model compared every clock,
// plus directed checks per requirement.
module wdt_timer_test;
    localparam int CW   = 12;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0, dbg_halt = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, match_out, rst_int_o, rst_ext_o;

    wdt_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt(dbg_halt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .match_out(match_out),
        .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int int_hi = 0, ext_hi = 0;
    bit done = 0;

    // reference model state
    bit m_en, m_clr, m_dbg, m_flag, m_lvl, m_cause;
    int m_cnt, m_mval, m_len, m_pi, m_pe;
    bit [6:0] m_mctl;
    bit [1:0] m_act;

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return int'(m_flag);
            1: return {m_dbg, m_clr, m_en};
            2: return m_cnt;
            3: return int'(m_mctl);
            4: return m_mval;
            5: return (int'(m_act) << 4) | int'(m_lvl);
            6: return m_len;
            default: return int'(m_cause);
        endcase
    endfunction

    // model step at each edge, then compare outputs 2 ns later
    always @(posedge clk) begin
        bit run, hit, si, se;
        int a;
        a   = int'(bus_addr);
        run = m_en && !m_clr && !(m_dbg && dbg_halt);
        hit = run && (m_cnt == m_mval);
        si  = (hit && m_mctl[3]) || m_mctl[5];
        se  = (hit && m_mctl[4]) || m_mctl[6];
        if (!por_n) m_cause = 0;
        else if (rst_n && (si || se)) m_cause = 1;
        if (!(rst_n && por_n)) begin
            m_en = 0; m_clr = 0; m_dbg = 0; m_flag = 0; m_lvl = 0;
            m_cnt = 0; m_mval = 0; m_len = 0; m_pi = 0; m_pe = 0;
            m_mctl = 0; m_act = 0;
        end else begin
            if (m_clr) m_cnt = 0;
            else if (hit && m_mctl[2]) m_cnt = 0;
            else if (run) m_cnt = (m_cnt + 1) & MASK;
            if (bus_we && a == 1) begin
                m_en = bus_wdata[0]; m_clr = bus_wdata[1]; m_dbg = bus_wdata[2];
            end else if (hit && m_mctl[2]) m_en = 0;
            if (hit && m_mctl[0]) m_flag = 1;
            else if (bus_we && a == 0 && bus_wdata[0]) m_flag = 0;
            if (bus_we && a == 5) begin
                m_act = bus_wdata[5:4]; m_lvl = bus_wdata[0];
            end else if (hit) begin
                if (m_act == 1) m_lvl = 0;
                else if (m_act == 2) m_lvl = 1;
                else if (m_act == 3) m_lvl = !m_lvl;
            end
            if (si) m_pi = m_len + 6; else if (m_pi > 0) m_pi--;
            if (se) m_pe = m_len + 6; else if (m_pe > 0) m_pe--;
            if (bus_we && a == 3) m_mctl = bus_wdata[6:0] & 7'h7D;
            if (bus_we && a == 4) m_mval = bus_wdata & MASK;
            if (bus_we && a == 6) m_len = bus_wdata[15:0];
        end
        #2;
        if (!done) begin
            check(irq == m_flag, "R5 model irq", irq, m_flag);
            check(match_out == m_lvl, "R9 model match_out", match_out, m_lvl);
            check(rst_int_o == (m_pi > 0), "R7 model rst_int_o", rst_int_o, m_pi > 0);
            check(rst_ext_o == (m_pe > 0), "R7 model rst_ext_o", rst_ext_o, m_pe > 0);
            check(bus_rdata == m_read(int'(bus_addr)), "R2 model rdata",
                  bus_rdata, m_read(int'(bus_addr)));
            if (rst_int_o) int_hi++;
            if (rst_ext_o) ext_hi++;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic rd_get(int a, output int v);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL timeout actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v1, v2;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        // R1 reset state
        for (int i = 0; i < 8; i++) rd(i, 0, "R1 reset readback");
        check({irq, match_out, rst_int_o, rst_ext_o} == 0, "R1 outputs", irq, 0);
        // R2 readback and reserved bit
        wr(4, 32'h123); rd(4, 32'h123, "R2 match value");
        wr(6, 3); rd(6, 3, "R2 pulse length");
        wr(3, 32'h1F); rd(3, 32'h1D, "R2 reserved bit");
        wr(3, 0);
        // R3 count, stop, clear
        wr(1, 2); wr(1, 1);
        repeat (6) @(negedge clk);
        wr(1, 0); rd_get(2, v1);
        check(v1 != 0, "R3 counter advanced", v1, 1);
        repeat (3) @(negedge clk);
        rd(2, v1, "R3 stop keeps value");
        wr(1, 2); rd(2, 0, "R3 clear to zero");
        // R4 debug freeze
        wr(1, 5); dbg_halt = 1;
        rd_get(2, v1); repeat (5) @(negedge clk);
        rd(2, v1, "R4 frozen");
        dbg_halt = 0; repeat (5) @(negedge clk);
        rd_get(2, v2); check(v2 != v1, "R4 resumes", v2, v1 + 1);
        wr(1, 1); dbg_halt = 1; rd_get(2, v1); repeat (3) @(negedge clk);
        rd_get(2, v2); check(v2 != v1, "R4 halt ignored when bit clear", v2, v1 + 3);
        dbg_halt = 0;
        // R5 R6 R7 R9 R10 match with stop and both resets
        wr(1, 2); wr(4, 20); wr(6, 3); wr(5, 32'h20); wr(3, 32'h1D);
        int_hi = 0; ext_hi = 0;
        wr(1, 1);
        repeat (40) @(negedge clk);
        check(irq == 1, "R5 irq set", irq, 1);
        check(match_out == 1, "R9 drive high", match_out, 1);
        check(int_hi == 9, "R7 internal pulse length", int_hi, 9);
        check(ext_hi == 9, "R7 external pulse length", ext_hi, 9);
        rd(7, 1, "R10 cause set");
        rd(1, 0, "R6 enable cleared");
        rd(2, 0, "R6 counter zero");
        rd(0, 1, "R5 status bit");
        wr(0, 1); rd(0, 0, "R5 write one clears");
        check(irq == 0, "R5 irq low", irq, 0);
        // R9 toggle
        wr(5, 32'h31); rd(5, 32'h31, "R9 level written");
        wr(1, 1); repeat (40) @(negedge clk);
        rd(5, 32'h30, "R9 toggle");
        wr(0, 1);
        // R10 survives rst_n, cleared by por_n
        @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        rd(7, 1, "R10 survives rst_n");
        rd(3, 0, "R1 rst_n clears match control");
        wr(7, 0); rd(7, 1, "R10 write ignored");
        @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
        rd(7, 0, "R10 por clears");
        // R8 forced internal reset
        wr(6, 3); int_hi = 0; ext_hi = 0;
        wr(3, 32'h20); repeat (3) @(negedge clk); wr(3, 0);
        repeat (20) @(negedge clk);
        check(int_hi == 13, "R8 forced internal length", int_hi, 13);
        check(ext_hi == 0, "R8 external untouched", ext_hi, 0);
        // R11 wrap
        wr(4, MASK); wr(1, 2); wr(1, 1);
        repeat (4101) @(negedge clk);
        rd(2, 6, "R11 wrap");
        // R12 longest pulse
        wr(1, 2); wr(6, 32'hFFFF); wr(4, 5); wr(3, 32'h0C);
        int_hi = 0; ext_hi = 0;
        wr(1, 1);
        repeat (65600) @(negedge clk);
        check(int_hi == 65541, "R12 maximum pulse", int_hi, 65541);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule